// File: doc/BRIEF.md
# Host Channel Interrupt Aggregator

This block gathers the event interrupts of a set of host channels into one interrupt request line. Each channel keeps eleven sticky event flags and an enable mask with the same bit layout. A channel with any flag that is both set and enabled raises its bit in a read-only summary vector. That vector is filtered by a summary mask, and the result drives one bit of a global status word. The request output rises only when that global bit is enabled in the global mask and the master enable in the configuration word is set.

The channel engines report events as one-cycle pulses on a flat input vector, with channel n occupying bits n*11 to n*11+10. Software reads all state through a simple word-addressed register port. It writes 1 to clear event flags and writes plain values to the masks and the enable. Register reads are combinational from the address.

Top module: `hc_irq_agg`

## Requirements
- R1: After reset, every flag, mask and enable reads as zero and `irq` is low.
- R2: A pulse on event bit k of channel n sets bit k of that channel's status word, and the bit stays set until it is cleared. The bit order from 0 is: transfer done, halted, bus error, STALL, NAK, ACK, NYET, transaction error, babble, frame overrun, toggle error.
- R3: Writing the channel status word clears exactly those flags whose write-data bit is 1 and leaves the other flags unchanged.
- R4: When an event pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: The channel mask word stores bits 10:0 of the written data. Bits 31:11 of both the status word and the mask word read as zero.
- R6: Bit n of the summary word (0x00C) is 1 when channel n has any flag that is set and also enabled in its mask. Writes to the summary word have no effect.
- R7: Bit 25 of the global status word (0x004) is 1 when the summary AND the summary mask (0x010, bit n for channel n) is non-zero. All other bits read zero, and writes to this word have no effect.
- R8: `irq` = enable bit 0 of config (0x000) AND global mask bit 25 (0x008) AND global status bit 25. It follows changes in the pending state in the same cycle.
- R9: Channel n's register group starts at 0x100 + 32*n and spans eight words, with status at +0x08 and mask at +0x0C. The other words of the group and any unassigned address read zero. Groups of channels at or above the channel count read zero and ignore writes.
- R10: Only bit 0 of the config word and only bit 25 of the global mask word can be written. All other bits of those words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_pulse | input | NUM_CH*EV_W | One-cycle event pulses, channel n at bits n*EV_W +: EV_W |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Aggregated interrupt request |

## Verification
The bench builds the block with NUM_CH set to 5 and EV_W left at 11. With five channels, the last implemented group (channel 4) can be checked next to an unimplemented group (channel 7), and the summary and summary-mask widths stay narrow enough that every bit can be predicted by hand. The scoreboard covers the set-beats-clear collision, partial write-1 clears, and a case where `irq` drops at once when a channel is masked out of the summary.

// File: rtl/hcia_pkg.sv
package hcia_pkg;

  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 32;
  localparam int GSTS_CH_BIT = 25;
  localparam int CFG_EN_BIT  = 0;
  localparam logic [ADDR_W-1:0] CH_BASE  = 12'h100;
  localparam logic [ADDR_W-1:0] CH_LIMIT = 12'h300;

  typedef enum logic [2:0] {
    RG_NONE, RG_CFG, RG_GSTS, RG_GMSK, RG_SUM, RG_SMSK, RG_CST, RG_CMSK
  } hcia_reg_e;

  typedef struct packed {
    hcia_reg_e  kind;
    logic [3:0] ch;
  } hcia_sel_t;

  // Map a byte address onto a register kind and a channel index.
  function automatic hcia_sel_t hcia_decode(input logic [ADDR_W-1:0] a);
    hcia_sel_t s;
    logic [ADDR_W-1:0] off;
    s.kind = RG_NONE;
    s.ch   = '0;
    off    = a - CH_BASE;
    if (a[1:0] == 2'b00) begin
      if (a >= CH_BASE && a < CH_LIMIT) begin
        s.ch = off[8:5];
        case (off[4:2])
          3'd2:    s.kind = RG_CST;
          3'd3:    s.kind = RG_CMSK;
          default: s.kind = RG_NONE;
        endcase
      end else begin
        case (a)
          12'h000: s.kind = RG_CFG;
          12'h004: s.kind = RG_GSTS;
          12'h008: s.kind = RG_GMSK;
          12'h00C: s.kind = RG_SUM;
          12'h010: s.kind = RG_SMSK;
          default: s.kind = RG_NONE;
        endcase
      end
    end
    return s;
  endfunction

  // Next value of a sticky flag word: clear by write-1, then set by events.
  function automatic logic [31:0] hcia_sticky_next(input logic [31:0] cur,
                                                   input logic [31:0] clr,
                                                   input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/hcia_chan.sv
module hcia_chan
  import hcia_pkg::*;
#(
  parameter int EV_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev,
  input  logic            clr_we,
  input  logic            msk_we,
  input  logic [EV_W-1:0] wdata,
  output logic [EV_W-1:0] status,
  output logic [EV_W-1:0] mask,
  output logic            pending
);

  logic [EV_W-1:0] clr_bits;
  logic [31:0]     nxt_wide;

  assign clr_bits = clr_we ? wdata : '0;
  assign nxt_wide = hcia_sticky_next(32'(status), 32'(clr_bits), 32'(ev));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= nxt_wide[EV_W-1:0];
      if (msk_we) mask <= wdata;
    end
  end

  assign pending = |(status & mask);

endmodule

// File: rtl/hcia_global.sv
module hcia_global
  import hcia_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] sum_vec,
  input  logic              cfg_we,
  input  logic              gmsk_we,
  input  logic              smsk_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              cfg_en,
  output logic              gmsk_ch,
  output logic [NUM_CH-1:0] smask,
  output logic              gsts_ch,
  output logic              irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en  <= 1'b0;
      gmsk_ch <= 1'b0;
      smask   <= '0;
    end else begin
      if (cfg_we)  cfg_en  <= wdata[CFG_EN_BIT];
      if (gmsk_we) gmsk_ch <= wdata[GSTS_CH_BIT];
      if (smsk_we) smask   <= wdata[NUM_CH-1:0];
    end
  end

  assign gsts_ch = |(sum_vec & smask);
  assign irq     = cfg_en & gmsk_ch & gsts_ch;

endmodule

// File: rtl/hc_irq_agg.sv
module hc_irq_agg
  import hcia_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int EV_W   = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH*EV_W-1:0] ev_pulse,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   irq
);

  localparam int FLAT_W = NUM_CH * EV_W;

  hcia_sel_t         sel;
  logic [EV_W-1:0]   st_arr  [NUM_CH];
  logic [EV_W-1:0]   msk_arr [NUM_CH];
  logic [NUM_CH-1:0] sum_vec;
  logic [FLAT_W-1:0] st_flat;
  logic              cfg_en, gmsk_ch, gsts_ch;
  logic [NUM_CH-1:0] smask;

  assign sel = hcia_decode(bus_addr);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (sel.ch == 4'(g));
    hcia_chan #(.EV_W(EV_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev_pulse[g*EV_W +: EV_W]),
      .clr_we  (bus_wr && hit && sel.kind == RG_CST),
      .msk_we  (bus_wr && hit && sel.kind == RG_CMSK),
      .wdata   (bus_wdata[EV_W-1:0]),
      .status  (st_arr[g]),
      .mask    (msk_arr[g]),
      .pending (sum_vec[g])
    );
    assign st_flat[g*EV_W +: EV_W] = st_arr[g];
  end

  hcia_global #(.NUM_CH(NUM_CH)) u_glb (
    .clk     (clk),
    .rst_n   (rst_n),
    .sum_vec (sum_vec),
    .cfg_we  (bus_wr && sel.kind == RG_CFG),
    .gmsk_we (bus_wr && sel.kind == RG_GMSK),
    .smsk_we (bus_wr && sel.kind == RG_SMSK),
    .wdata   (bus_wdata),
    .cfg_en  (cfg_en),
    .gmsk_ch (gmsk_ch),
    .smask   (smask),
    .gsts_ch (gsts_ch),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel.kind)
      RG_CFG:  bus_rdata[CFG_EN_BIT]  = cfg_en;
      RG_GSTS: bus_rdata[GSTS_CH_BIT] = gsts_ch;
      RG_GMSK: bus_rdata[GSTS_CH_BIT] = gmsk_ch;
      RG_SUM:  bus_rdata[NUM_CH-1:0]  = sum_vec;
      RG_SMSK: bus_rdata[NUM_CH-1:0]  = smask;
      RG_CST: begin
        for (int i = 0; i < NUM_CH; i++)
          if (sel.ch == 4'(i)) bus_rdata[EV_W-1:0] = st_arr[i];
      end
      RG_CMSK: begin
        for (int i = 0; i < NUM_CH; i++)
          if (sel.ch == 4'(i)) bus_rdata[EV_W-1:0] = msk_arr[i];
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/hcia_chk.sv
module hcia_chk #(
  parameter int NUM_CH = 16,
  parameter int EV_W   = 11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [NUM_CH*EV_W-1:0] ev_pulse,
  input logic [NUM_CH*EV_W-1:0] st_flat,
  input logic [NUM_CH-1:0]      sum_vec,
  input logic [NUM_CH-1:0]      smask,
  input logic                   cfg_en,
  input logic                   gmsk_ch,
  input logic                   irq
);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (($past(st_flat) & ~st_flat) == '0));  // R2

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pulse != '0) |=> ((st_flat & $past(ev_pulse)) == $past(ev_pulse)));  // R4

  AST_SUM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_vec != '0) |-> (st_flat != '0));  // R6

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((sum_vec & smask) != '0));  // R7

  AST_IRQ_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cfg_en && gmsk_ch));  // R8

endmodule

bind hc_irq_agg hcia_chk #(.NUM_CH(NUM_CH), .EV_W(EV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .ev_pulse (ev_pulse),
  .st_flat  (st_flat),
  .sum_vec  (sum_vec),
  .smask    (smask),
  .cfg_en   (cfg_en),
  .gmsk_ch  (gmsk_ch),
  .irq      (irq)
);

// File: tb/hc_irq_agg_test.sv
`timescale 1ns/1ps
module hc_irq_agg_test;

  localparam int NCH  = 5;
  localparam int EVW  = 11;
  localparam int FLAT = NCH * EVW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [FLAT-1:0] ev_pulse = '0;
  logic            bus_wr = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [11:0] a;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  hc_irq_agg #(.NUM_CH(NCH), .EV_W(EVW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [11:0] st_a(input int ch);
    return 12'(12'h100 + 32 * ch + 8);
  endfunction
  function automatic logic [11:0] mk_a(input int ch);
    return 12'(12'h100 + 32 * ch + 12);
  endfunction
  function automatic logic [FLAT-1:0] evb(input int ch, input int bitn);
    logic [FLAT-1:0] v = '0;
    v[ch * EVW + bitn] = 1'b1;
    return v;
  endfunction

  task automatic step(input logic wr, input logic [11:0] a,
                      input logic [31:0] d, input logic [FLAT-1:0] ev);
    @(posedge clk); #1;
    bus_wr = wr; bus_addr = a; bus_wdata = d; ev_pulse = ev;
  endtask
  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0);
  endtask
  task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    item_t it;
    step(1'b0, a, 32'h0, '0);
    it.is_irq = 0; it.a = a; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask
  task automatic chk_irq(input logic e, input string t);
    item_t it;
    step(1'b0, 12'h000, 32'h0, '0);
    it.is_irq = 1; it.a = '0; it.exp = {31'b0, e}; it.tag = t;
    sb.push_back(it);
  endtask

  // Monitor: compare the oldest expected item against the outputs.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {31'b0, irq} : bus_rdata;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, act, it.exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk_rd(12'h000, 32'h0, "R1 cfg");
    chk_rd(12'h004, 32'h0, "R1 gsts");
    chk_rd(mk_a(0), 32'h0, "R1 mask");
    chk_irq(1'b0, "R1 irq");
    // R2 events on channel 1: transfer done (bit0) and toggle error (bit10)
    step(1'b0, 12'h000, 32'h0, evb(1, 0) | evb(1, 10));
    chk_rd(st_a(1), 32'h401, "R2 ch1 status");
    chk_rd(st_a(1), 32'h401, "R2 sticky");
    chk_rd(st_a(0), 32'h0, "R2 ch0 untouched");
    chk_rd(12'h00C, 32'h0, "R6 summary masked");
    // R5 mask width
    wr_reg(mk_a(1), 32'hFFFF_FFFF);
    chk_rd(mk_a(1), 32'h7FF, "R5 mask bits");
    chk_rd(12'h00C, 32'h02, "R6 summary ch1");
    chk_rd(12'h004, 32'h0, "R7 smask zero");
    wr_reg(12'h010, 32'h1F);
    chk_rd(12'h004, 32'h0200_0000, "R7 gsts bit25");
    chk_irq(1'b0, "R8 no enables");
    wr_reg(12'h008, 32'hFFFF_FFFF);
    chk_rd(12'h008, 32'h0200_0000, "R10 gmask bits");
    chk_irq(1'b0, "R8 cfg off");
    wr_reg(12'h000, 32'hFFFF_FFFF);
    chk_rd(12'h000, 32'h1, "R10 cfg bits");
    chk_irq(1'b1, "R8 irq on");
    // R6/R7 read-only words
    wr_reg(12'h00C, 32'h0);
    chk_rd(12'h00C, 32'h02, "R6 summary write ignored");
    wr_reg(12'h004, 32'hFFFF_FFFF);
    chk_rd(12'h004, 32'h0200_0000, "R7 gsts write ignored");
    // R3 partial clear
    wr_reg(st_a(1), 32'h001);
    chk_rd(st_a(1), 32'h400, "R3 partial clear");
    // R4 set and clear together
    step(1'b1, st_a(1), 32'h401, evb(1, 0));
    chk_rd(st_a(1), 32'h001, "R4 set wins");
    chk_irq(1'b1, "R8 still pending");
    wr_reg(st_a(1), 32'hFFFF_FFFF);
    chk_rd(st_a(1), 32'h0, "R3 full clear");
    chk_irq(1'b0, "R8 irq follows");
    // R9 last channel, unimplemented channel, other group words
    step(1'b0, 12'h000, 32'h0, evb(4, 5));
    chk_rd(st_a(4), 32'h020, "R9 ch4 status");
    wr_reg(mk_a(7), 32'h7FF);
    chk_rd(mk_a(7), 32'h0, "R9 ch7 absent");
    chk_rd(12'h120, 32'h0, "R9 group word0");
    chk_rd(12'h014, 32'h0, "R9 unassigned");
    wr_reg(mk_a(4), 32'h020);
    chk_rd(12'h00C, 32'h10, "R6 summary ch4");
    chk_irq(1'b1, "R8 ch4 irq");
    wr_reg(12'h010, 32'h0F);
    chk_irq(1'b0, "R7 smask drops ch4");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule